// File: doc/BRIEF.md
# Endian-Configurable Load/Store Lane Aligner

This block sits between a 32-bit core register path and a 32-bit external data bus and handles sub-word transfers. On a load it takes the byte or halfword at the addressed position of the incoming bus word and widens it to a full register value. Widening is by sign or by zero, as the request asks. On a store it builds the outgoing bus word from the source register, copying the narrow value into every lane it could occupy. The memory system then enables only the lanes it needs.

A static input selects little- or big-endian lane numbering. The low two address bits, the access size, the signed flag and the direction arrive with a one-cycle request strobe. The widened load result is registered and appears one cycle after the strobe, together with a result-valid pulse. The store word and the misalignment flag are combinational and valid in the cycle of the request.

Top module: `lane_aligner`

## Requirements
- R1: In little-endian mode (`cfg_big_endian`=0), a byte load at offset `req_addr`=k takes bus bits [8k+7:8k].
- R2: In big-endian mode (`cfg_big_endian`=1), a byte load at offset k takes bus bits [31-8k:24-8k]. Offset 0 maps to bits 31:24.
- R3: A halfword load (`req_half`=1) takes bus bits 15:0 when `req_addr[1]` XOR `cfg_big_endian` is 0, and bus bits 31:16 otherwise.
- R4: A byte load puts the byte in result bits 7:0. Bits 31:8 are copies of byte bit 7 when `req_signed`=1 and zero when `req_signed`=0.
- R5: A halfword load puts the halfword in result bits 15:0. Bits 31:16 are copies of halfword bit 15 when `req_signed`=1 and zero when `req_signed`=0.
- R6: For a halfword store, `bus_wdata` carries `src_data[15:0]` in both bits 15:0 and bits 31:16, in either endian mode.
- R7: For a byte store, `bus_wdata` carries `src_data[7:0]` in all four byte lanes, in either endian mode.
- R8: `misalign` is high in the same cycle exactly when `req_valid`=1, `req_half`=1 and `req_addr[0]`=1, for loads and stores alike.
- R9: `res_valid` is high in the cycle after a load request (`req_valid`=1, `req_store`=0), and low after any other cycle. `res_data` keeps its value when no load is requested.
- R10: A misaligned halfword load returns `res_data` equal to zero.
- R11: `req_signed` has no effect on `bus_wdata` for stores.
- R12: While `rst_n` is low, and in the first cycle after reset, `res_valid` and `res_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_big_endian | input | 1 | Lane numbering: 0 little-endian, 1 big-endian |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_store | input | 1 | 1 store, 0 load |
| req_half | input | 1 | Access size: 0 byte, 1 halfword |
| req_signed | input | 1 | Sign-extend on loads |
| req_addr | input | 2 | Low address bits (byte offset in the word) |
| bus_rdata | input | 32 | Word read from the external bus |
| src_data | input | 32 | Source register value for stores |
| bus_wdata | output | 32 | Word driven onto the external bus for stores |
| misalign | output | 1 | Halfword access at an odd address |
| res_valid | output | 1 | Load result valid |
| res_data | output | 32 | Widened load result |

## Verification
The store word and the misalignment flag come from the request through combinational logic only. The bench therefore checks them shortly after it drives the request, before the next rising edge. The load result passes through one register and is due at the first rising edge after the strobe. The driver queues each expected load value when it issues the request. The monitor samples on the falling edge after that rising edge and pops one entry each time `res_valid` is seen. A valid pulse with nothing queued, or entries still queued at the end, counts as a failure.

// File: rtl/lane_pkg.sv
package lane_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic {
        ACC_BYTE = 1'b0,
        ACC_HALF = 1'b1
    } acc_size_e;

endpackage

// File: rtl/lane_pick.sv
module lane_pick #(
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned LANE_W = 8
) (
    input  logic                          big_endian,
    input  lane_pkg::acc_size_e           size,
    input  logic                          sign_ext,
    input  logic [$clog2(BUS_W/LANE_W)-1:0] offset,
    input  logic [BUS_W-1:0]              word_in,
    output logic [BUS_W-1:0]              value_out
);
    localparam int unsigned NLANE  = BUS_W / LANE_W;
    localparam int unsigned HALF_W = 2 * LANE_W;
    localparam int unsigned NHALF  = NLANE / 2;
    localparam int unsigned OFS_W  = $clog2(NLANE);
    localparam int unsigned HID_W  = (OFS_W > 1) ? OFS_W - 1 : 1;

    logic [LANE_W-1:0] lane_v [NLANE];
    logic [HALF_W-1:0] half_v [NHALF];

    for (genvar li = 0; li < NLANE; li++) begin : g_lane
        assign lane_v[li] = word_in[li*LANE_W +: LANE_W];
    end
    for (genvar hi = 0; hi < NHALF; hi++) begin : g_half
        assign half_v[hi] = word_in[hi*HALF_W +: HALF_W];
    end

    logic [OFS_W-1:0]  byte_idx;
    logic [HID_W-1:0]  half_idx;
    logic [LANE_W-1:0] byte_sel;
    logic [HALF_W-1:0] half_sel;

    always_comb begin
        // Big-endian numbering counts lanes from the top of the bus.
        byte_idx = big_endian ? (OFS_W'(NLANE - 1) - offset) : offset;
        half_idx = big_endian ? (HID_W'(NHALF - 1) - offset[OFS_W-1:1])
                              : offset[OFS_W-1:1];
        byte_sel = lane_v[byte_idx];
        half_sel = half_v[half_idx];
        if (size == lane_pkg::ACC_HALF) begin
            value_out = {{(BUS_W-HALF_W){sign_ext & half_sel[HALF_W-1]}}, half_sel};
        end else begin
            value_out = {{(BUS_W-LANE_W){sign_ext & byte_sel[LANE_W-1]}}, byte_sel};
        end
    end

endmodule

// File: rtl/store_pack.sv
module store_pack #(
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned LANE_W = 8
) (
    input  lane_pkg::acc_size_e size,
    input  logic [BUS_W-1:0]    src,
    output logic [BUS_W-1:0]    word_out
);
    localparam int unsigned NLANE = BUS_W / LANE_W;

    // Each lane copies the narrow value; endian mode plays no part.
    for (genvar li = 0; li < NLANE; li++) begin : g_lane
        localparam int unsigned HPART = li % 2;
        assign word_out[li*LANE_W +: LANE_W] =
            (size == lane_pkg::ACC_HALF) ? src[HPART*LANE_W +: LANE_W]
                                         : src[LANE_W-1:0];
    end

endmodule

// File: rtl/lane_aligner.sv
module lane_aligner #(
    parameter int unsigned BUS_W  = lane_pkg::WORD_W,
    parameter int unsigned LANE_W = lane_pkg::BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_big_endian,
    input  logic             req_valid,
    input  logic             req_store,
    input  logic             req_half,
    input  logic             req_signed,
    input  logic [1:0]       req_addr,
    input  logic [BUS_W-1:0] bus_rdata,
    input  logic [BUS_W-1:0] src_data,
    output logic [BUS_W-1:0] bus_wdata,
    output logic             misalign,
    output logic             res_valid,
    output logic [BUS_W-1:0] res_data
);
    localparam int unsigned HALF_W = 2 * LANE_W;

    typedef struct packed {
        logic             valid;
        logic [BUS_W-1:0] data;
    } res_state_t;

    res_state_t          st_d, st_q;
    lane_pkg::acc_size_e size_w;
    logic [BUS_W-1:0]    picked_w;
    logic                load_fire_w;

    assign size_w = lane_pkg::acc_size_e'(req_half);

    lane_pick #(.BUS_W(BUS_W), .LANE_W(LANE_W)) pick_i (
        .big_endian (cfg_big_endian),
        .size       (size_w),
        .sign_ext   (req_signed),
        .offset     (req_addr),
        .word_in    (bus_rdata),
        .value_out  (picked_w)
    );

    store_pack #(.BUS_W(BUS_W), .LANE_W(LANE_W)) pack_i (
        .size     (size_w),
        .src      (src_data),
        .word_out (bus_wdata)
    );

    always_comb begin
        misalign    = req_valid && req_half && req_addr[0];
        load_fire_w = req_valid && !req_store;
        st_d        = st_q;
        st_d.valid  = load_fire_w;
        if (load_fire_w) begin
            st_d.data = misalign ? '0 : picked_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.valid;
    assign res_data  = st_q.data;

    p_valid_after_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store) |=> res_valid);

    p_no_valid_otherwise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_store) |=> !res_valid);

    p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_store) |=> $stable(res_data));

    p_misalign_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && req_half && req_addr[0]) |=> (res_data == '0));

    p_half_store_dup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_half)
            |-> (bus_wdata[BUS_W-1:HALF_W] == src_data[HALF_W-1:0]
                 && bus_wdata[HALF_W-1:0] == src_data[HALF_W-1:0]));

    p_byte_store_repl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && !req_half)
            |-> (bus_wdata[BUS_W-1:BUS_W-LANE_W] == src_data[LANE_W-1:0]));

    p_misalign_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (req_valid && req_half));

    p_signed_half_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && req_half && req_signed && !req_addr[0])
            |=> ($countones(res_data[BUS_W-1:HALF_W-1]) == 0
                 || $countones(res_data[BUS_W-1:HALF_W-1]) == BUS_W-HALF_W+1));

endmodule

// File: tb/lane_aligner_tb.sv
`timescale 1ns/1ps
module lane_aligner_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_big_endian = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic        req_half = 1'b0;
    logic        req_signed = 1'b0;
    logic [1:0]  req_addr = 2'd0;
    logic [31:0] bus_rdata = '0;
    logic [31:0] src_data = '0;
    logic [31:0] bus_wdata;
    logic        misalign;
    logic        res_valid;
    logic [31:0] res_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    lane_aligner dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_big_endian(cfg_big_endian),
        .req_valid(req_valid), .req_store(req_store), .req_half(req_half),
        .req_signed(req_signed), .req_addr(req_addr), .bus_rdata(bus_rdata),
        .src_data(src_data), .bus_wdata(bus_wdata), .misalign(misalign),
        .res_valid(res_valid), .res_data(res_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_load(input logic be, input logic half,
            input logic sgn, input logic [1:0] a, input logic [31:0] w);
        logic [15:0] h;
        logic [7:0]  b;
        if (half && a[0]) return 32'h0;
        if (half) begin
            h = (a[1] ^ be) ? w[31:16] : w[15:0];
            return {{16{sgn & h[15]}}, h};
        end
        b = w[8*(be ? (3 - a) : a) +: 8];
        return {{24{sgn & b[7]}}, b};
    endfunction

    task automatic do_load(input string req, input logic be, input logic half,
            input logic sgn, input logic [1:0] a, input logic [31:0] w);
        @(negedge clk);
        cfg_big_endian = be; req_valid = 1'b1; req_store = 1'b0;
        req_half = half; req_signed = sgn; req_addr = a; bus_rdata = w;
        exp_q.push_back(model_load(be, half, sgn, a, w));
        tag_q.push_back(req);
        #0.5;
        check({req, "/R8 misalign"}, {31'b0, misalign}, {31'b0, half & a[0]});
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_store(input string req, input logic be, input logic half,
            input logic sgn, input logic [1:0] a, input logic [31:0] s);
        logic [31:0] e;
        @(negedge clk);
        cfg_big_endian = be; req_valid = 1'b1; req_store = 1'b1;
        req_half = half; req_signed = sgn; req_addr = a; src_data = s;
        e = half ? {2{s[15:0]}} : {4{s[7:0]}};
        #0.5;
        check(req, bus_wdata, e);
        check({req, "/R8 misalign"}, {31'b0, misalign}, {31'b0, half & a[0]});
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: one expected entry per result-valid pulse.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected res_valid", 32'h1, 32'h0);
            end else begin
                check(tag_q.pop_front(), res_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset valid", {31'b0, res_valid}, 32'h0);
        check("R12 reset data", res_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 after reset valid", {31'b0, res_valid}, 32'h0);
        check("R12 after reset data", res_data, 32'h0);

        for (int k = 0; k < 4; k++) begin
            do_load("R1 LE byte lane", 1'b0, 1'b0, 1'b0, 2'(k), 32'h8C_5A_F1_23);
            do_load("R2 BE byte lane", 1'b1, 1'b0, 1'b0, 2'(k), 32'h8C_5A_F1_23);
        end
        do_load("R4 signed byte neg", 1'b0, 1'b0, 1'b1, 2'd1, 32'h0000_9A00);
        do_load("R4 signed byte pos", 1'b1, 1'b0, 1'b1, 2'd2, 32'hFFFF_7FFF);
        do_load("R4 unsigned byte high", 1'b0, 1'b0, 1'b0, 2'd3, 32'hF0FF_FFFF);
        do_load("R3 LE half low", 1'b0, 1'b1, 1'b0, 2'd0, 32'hBEEF_CAFE);
        do_load("R3 LE half high", 1'b0, 1'b1, 1'b0, 2'd2, 32'hBEEF_CAFE);
        do_load("R3 BE half low addr", 1'b1, 1'b1, 1'b0, 2'd0, 32'hBEEF_CAFE);
        do_load("R3 BE half high addr", 1'b1, 1'b1, 1'b0, 2'd2, 32'hBEEF_CAFE);
        do_load("R5 signed half neg", 1'b0, 1'b1, 1'b1, 2'd2, 32'h8001_0000);
        do_load("R5 signed half pos", 1'b1, 1'b1, 1'b1, 2'd0, 32'h7FFE_FFFF);
        do_load("R5 unsigned half", 1'b1, 1'b1, 1'b0, 2'd2, 32'h0000_F00D);
        do_load("R10 misaligned half addr1", 1'b0, 1'b1, 1'b1, 2'd1, 32'hFFFF_FFFF);
        do_load("R10 misaligned half addr3", 1'b1, 1'b1, 1'b0, 2'd3, 32'h1234_5678);

        // R9: hold and no valid after stores and idle cycles.
        @(negedge clk);
        check("R9 idle no valid", {31'b0, res_valid}, 32'h0);
        check("R9 idle hold data", res_data, 32'h0);

        do_store("R6 half store LE", 1'b0, 1'b1, 1'b0, 2'd0, 32'hDEAD_4C3B);
        do_store("R6 half store BE", 1'b1, 1'b1, 1'b0, 2'd2, 32'hDEAD_4C3B);
        do_store("R7 byte store LE", 1'b0, 1'b0, 1'b0, 2'd1, 32'h1234_56A7);
        do_store("R7 byte store BE", 1'b1, 1'b0, 1'b0, 2'd3, 32'h1234_56A7);
        do_store("R11 signed ignored half", 1'b0, 1'b1, 1'b1, 2'd0, 32'h0000_80F0);
        do_store("R11 signed ignored byte", 1'b1, 1'b0, 1'b1, 2'd0, 32'h0000_0080);
        do_store("R8 misaligned store", 1'b0, 1'b1, 1'b0, 2'd1, 32'h0000_1111);

        do_load("R9 load after stores", 1'b0, 1'b0, 1'b0, 2'd0, 32'h0000_0055);
        repeat (2) @(negedge clk);
        check("R9 hold after load", res_data, 32'h0000_0055);
        check("R9 valid pulse ended", {31'b0, res_valid}, 32'h0);
        check("R9 queue drained", 32'(exp_q.size()), 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule